// File: doc/BRIEF.md
# Status, Interrupt and DMA-Request Unit

This block keeps the event status word and the interrupt-enable mask of a bus-master serial controller. It combines them into a single interrupt line and two DMA request lines, one for receive and one for transmit. The transfer engine raises status bits with one-cycle set pulses. Software reaches the unit through a small register port that exposes the status word, the enable mask, the buffer configuration, a priority vector and a test register. Two controller generations are supported, selected by a revision strap. The older generation has a vector read that both reports and acknowledges an event, and its status word is read-only. The newer generation drops the vector and lets software clear status bits directly.

The register port is strobed. `reg_sel` selects a register, and `reg_wr` and `reg_rd` are single-cycle strobes. Read data is registered: it appears on the cycle after the read strobe and is held until the next read. The interrupt and DMA outputs are also registered, so they reflect the status and mask as they stood one cycle earlier.

Top module: `sirq_unit`

## Requirements
- R1: `irq` is high on the cycle after any cycle in which the stored status word ANDed with the enable mask is nonzero, and low otherwise.
- R2: `dma_rx_req` follows status bit 3 (receive ready) one cycle later, but only while the receive DMA enable is set. `dma_tx_req` follows status bit 4 (transmit ready) one cycle later, but only while the transmit DMA enable is set. Each request is 0 while its enable is clear.
- R3: A write to the buffer register (select 2) stores only data bit 15 (receive DMA enable) and bit 7 (transmit DMA enable), and reads back with all other bits 0. Writing bit 15 as 1 clears mask bit 3, and writing bit 7 as 1 clears mask bit 4, in the same cycle.
- R4: With the revision strap below 0x34, a vector read (select 3) returns the 1-based position of the lowest set bit of status AND mask, or 0 if none is set. The same read clears that status bit.
- R5: With the revision strap at or above 0x34, a vector read returns 0 and changes no status bit.
- R6: A mask write (select 1) keeps data bits 4:0 when the strap is below 0x34, and bits 5:0 otherwise.
- R7: At or above 0x34, a status write (select 0) clears each status bit written as 1 within 0x0027. Below 0x34, a status write has no effect.
- R8: A status read returns the stored status with bit 12 replaced by the live `bus_busy` input. A set pulse on bit 12 is never stored.
- R9: At or above 0x34, a test-register write (select 4) with data bit 11 set forces status bits 5:0 to 1. Below 0x34 it has no effect. The test register always reads 0.
- R10: When a set pulse and a software clear (status write or vector read) hit the same status bit in the same cycle, the bit ends up set.
- R11: Asynchronous reset clears every register and output. A `soft_rst` cycle clears the status, mask and both DMA enables, overriding any set or write in that cycle.
- R12: Read data for a strobe on cycle N appears on `reg_rdata` from cycle N+1 and holds until the next read strobe. Selects 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous clear of status, mask and DMA enables |
| rev_strap | input | 8 | Controller revision; at or above 0x34 selects the newer generation |
| evt_set | input | 16 | One-cycle set pulses from the transfer engine, one per status bit |
| bus_busy | input | 1 | Live bus-busy indication, shown as status bit 12 on reads |
| reg_sel | input | 3 | Register select: 0 status, 1 mask, 2 buffer, 3 vector, 4 test |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
A wrong status or mask bit shows on `irq` or on a DMA request exactly one cycle after it is stored. A corrupted bit that is masked off and not DMA-enabled stays hidden until a status, mask or vector read brings it out one cycle after the strobe. The acknowledge side effect of the vector read is confirmed by the next read of the status word or the vector. The behavioural model predicts every output on every clock, so the first divergence is flagged in the cycle it appears.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
    typedef enum logic [2:0] {
        SEL_STAT = 3'd0,
        SEL_MASK = 3'd1,
        SEL_BUF  = 3'd2,
        SEL_VEC  = 3'd3,
        SEL_TEST = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/sirq_lowbit_enc.sv
module sirq_lowbit_enc #(
    parameter int W  = 16,
    parameter int IW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_in,
    output logic [W-1:0]  onehot,
    output logic [IW-1:0] idx
);
    logic [W:0] seen;
    assign seen[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_chain
            assign onehot[gi]   = vec_in[gi] & ~seen[gi];
            assign seen[gi + 1] = seen[gi] | vec_in[gi];
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_in[i]) idx = IW'(i + 1);
        end
    end
endmodule

// File: rtl/sirq_regfile.sv
module sirq_regfile #(
    parameter int          DW          = 16,
    parameter int          MW          = 6,
    parameter int          BUSY_BIT    = 12,
    parameter int          RX_EN_BIT   = 15,
    parameter int          TX_EN_BIT   = 7,
    parameter int          RX_RDY_BIT  = 3,
    parameter int          TX_RDY_BIT  = 4,
    parameter int          FORCE_BIT   = 11,
    parameter logic [15:0] W1C_MASK    = 16'h0027,
    parameter logic [15:0] FORCE_MASK  = 16'h003F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          new_rev,
    input  logic [DW-1:0] evt_set,
    input  logic [DW-1:0] vec_ack,
    input  logic          stat_wr,
    input  logic          mask_wr,
    input  logic          buf_wr,
    input  logic          test_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] status_q,
    output logic [MW-1:0] mask_q,
    output logic          rx_en_q,
    output logic          tx_en_q
);
    localparam logic [DW-1:0] STORE_MASK = ~(DW'(1) << BUSY_BIT);
    localparam logic [MW-1:0] OLD_KEEP   = MW'((1 << (MW - 1)) - 1);
    localparam logic [MW-1:0] NEW_KEEP   = '1;

    logic [DW-1:0] set_v, clr_v, status_d;
    logic [MW-1:0] mask_d;
    logic          rx_en_d, tx_en_d;

    always_comb begin
        set_v = evt_set & STORE_MASK;
        if (test_wr && new_rev && wdata[FORCE_BIT]) set_v = set_v | DW'(FORCE_MASK);
        clr_v = vec_ack;
        if (stat_wr && new_rev) clr_v = clr_v | (wdata & DW'(W1C_MASK));
        status_d = (status_q & ~clr_v) | set_v;
    end

    always_comb begin
        mask_d  = mask_q;
        rx_en_d = rx_en_q;
        tx_en_d = tx_en_q;
        if (mask_wr) begin
            mask_d = wdata[MW-1:0] & (new_rev ? NEW_KEEP : OLD_KEEP);
        end
        if (buf_wr) begin
            rx_en_d = wdata[RX_EN_BIT];
            tx_en_d = wdata[TX_EN_BIT];
            if (wdata[RX_EN_BIT]) mask_d[RX_RDY_BIT] = 1'b0;
            if (wdata[TX_EN_BIT]) mask_d[TX_RDY_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '0;
            rx_en_q  <= 1'b0;
            tx_en_q  <= 1'b0;
        end else if (soft_rst) begin
            status_q <= '0;
            mask_q   <= '0;
            rx_en_q  <= 1'b0;
            tx_en_q  <= 1'b0;
        end else begin
            status_q <= status_d;
            mask_q   <= mask_d;
            rx_en_q  <= rx_en_d;
            tx_en_q  <= tx_en_d;
        end
    end
endmodule

// File: rtl/sirq_outreg.sv
module sirq_outreg #(
    parameter int DW         = 16,
    parameter int MW         = 6,
    parameter int RX_RDY_BIT = 3,
    parameter int TX_RDY_BIT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] status_q,
    input  logic [MW-1:0] mask_q,
    input  logic          rx_en_q,
    input  logic          tx_en_q,
    output logic          irq,
    output logic          dma_rx_req,
    output logic          dma_tx_req
);
    logic [MW-1:0] pend_low;
    assign pend_low = status_q[MW-1:0] & mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq        <= 1'b0;
            dma_rx_req <= 1'b0;
            dma_tx_req <= 1'b0;
        end else begin
            irq        <= |pend_low;
            dma_rx_req <= rx_en_q & status_q[RX_RDY_BIT];
            dma_tx_req <= tx_en_q & status_q[TX_RDY_BIT];
        end
    end
endmodule

// File: rtl/sirq_unit.sv
module sirq_unit #(
    parameter int          DW        = 16,
    parameter int          MW        = 6,
    parameter int          REV_W     = 8,
    parameter logic [7:0]  NEW_REV   = 8'h34,
    parameter int          BUSY_BIT  = 12,
    parameter int          RX_EN_BIT = 15,
    parameter int          TX_EN_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic [REV_W-1:0] rev_strap,
    input  logic [DW-1:0]    evt_set,
    input  logic             bus_busy,
    input  logic [2:0]       reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             irq,
    output logic             dma_rx_req,
    output logic             dma_tx_req
);
    import sirq_pkg::*;

    localparam int IW = $clog2(DW + 1);

    reg_sel_e      sel;
    logic          new_rev;
    logic [DW-1:0] status_q;
    logic [MW-1:0] mask_q;
    logic          rx_en_q, tx_en_q;
    logic [DW-1:0] mask_ext, pend, vec_oh, vec_ack, rd_mux;
    logic [IW-1:0] vec_idx;
    logic          stat_wr, mask_wr, buf_wr, test_wr, vec_rd;

    assign sel      = reg_sel_e'(reg_sel);
    assign new_rev  = (rev_strap >= REV_W'(NEW_REV));
    assign mask_ext = {{(DW - MW){1'b0}}, mask_q};
    assign pend     = status_q & mask_ext;

    assign stat_wr = reg_wr && (sel == SEL_STAT);
    assign mask_wr = reg_wr && (sel == SEL_MASK);
    assign buf_wr  = reg_wr && (sel == SEL_BUF);
    assign test_wr = reg_wr && (sel == SEL_TEST);
    assign vec_rd  = reg_rd && (sel == SEL_VEC) && !new_rev;
    assign vec_ack = vec_rd ? vec_oh : '0;

    sirq_lowbit_enc #(.W(DW), .IW(IW)) u_enc (
        .vec_in (pend),
        .onehot (vec_oh),
        .idx    (vec_idx)
    );

    sirq_regfile #(
        .DW(DW), .MW(MW), .BUSY_BIT(BUSY_BIT),
        .RX_EN_BIT(RX_EN_BIT), .TX_EN_BIT(TX_EN_BIT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .new_rev  (new_rev),
        .evt_set  (evt_set),
        .vec_ack  (vec_ack),
        .stat_wr  (stat_wr),
        .mask_wr  (mask_wr),
        .buf_wr   (buf_wr),
        .test_wr  (test_wr),
        .wdata    (reg_wdata),
        .status_q (status_q),
        .mask_q   (mask_q),
        .rx_en_q  (rx_en_q),
        .tx_en_q  (tx_en_q)
    );

    sirq_outreg #(.DW(DW), .MW(MW)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .status_q   (status_q),
        .mask_q     (mask_q),
        .rx_en_q    (rx_en_q),
        .tx_en_q    (tx_en_q),
        .irq        (irq),
        .dma_rx_req (dma_rx_req),
        .dma_tx_req (dma_tx_req)
    );

    always_comb begin
        unique case (sel)
            SEL_STAT: rd_mux = status_q | (DW'(bus_busy) << BUSY_BIT);
            SEL_MASK: rd_mux = mask_ext;
            SEL_BUF:  rd_mux = (DW'(rx_en_q) << RX_EN_BIT) | (DW'(tx_en_q) << TX_EN_BIT);
            SEL_VEC:  rd_mux = new_rev ? '0 : {{(DW - IW){1'b0}}, vec_idx};
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end
endmodule

// File: rtl/sirq_unit_chk.sv
module sirq_unit_chk #(
    parameter int DW = 16,
    parameter int MW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          soft_rst,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [2:0]    reg_sel,
    input logic [DW-1:0] evt_set,
    input logic          new_rev,
    input logic [DW-1:0] status_q,
    input logic [MW-1:0] mask_q,
    input logic          rx_en_q,
    input logic          irq,
    input logic          dma_rx_req
);
    localparam logic [DW-1:0] STORE = ~(DW'(1) << 12);

    // R1
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q[MW-1:0] & mask_q) == '0) |=> !irq);

    // R2
    rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en_q |=> !dma_rx_req);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && ((evt_set & STORE) != '0)) |=>
        ((status_q & $past(evt_set & STORE)) == $past(evt_set & STORE)));

    // R7
    old_stat_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 3'd0 && !new_rev && evt_set == '0 && !soft_rst) |=>
        (status_q == $past(status_q)));

    // R6
    old_mask_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 3'd1 && !new_rev && !soft_rst) |=> !mask_q[MW-1]);

    // R4
    vec_ack_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel == 3'd3 && !new_rev && !reg_wr && !soft_rst &&
         evt_set == '0 && ((status_q[MW-1:0] & mask_q) != '0)) |=>
        ($countones(status_q) == $countones($past(status_q)) - 1));

    // R11
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (status_q == '0 && mask_q == '0 && !rx_en_q));
endmodule

bind sirq_unit sirq_unit_chk #(.DW(DW), .MW(MW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_sel    (reg_sel),
    .evt_set    (evt_set),
    .new_rev    (new_rev),
    .status_q   (status_q),
    .mask_q     (mask_q),
    .rx_en_q    (rx_en_q),
    .irq        (irq),
    .dma_rx_req (dma_rx_req)
);

// File: tb/sirq_unit_bench.sv
`timescale 1ns/1ps
module sirq_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [7:0]  rev_strap = 8'h11;
    logic [15:0] evt_set = '0;
    logic        bus_busy = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq, dma_rx_req, dma_tx_req;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    chk_en = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R12";
    string m_tag = "R11";

    always #2.5 clk = ~clk;

    sirq_unit u_sirq_unit (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rev_strap(rev_strap),
        .evt_set(evt_set), .bus_busy(bus_busy), .reg_sel(reg_sel),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .dma_rx_req(dma_rx_req),
        .dma_tx_req(dma_tx_req)
    );

    // behavioural reference
    logic [15:0] m_stat, m_rdata, pend, ns;
    logic [5:0]  m_mask, nm;
    logic        m_rx, m_tx, m_irq, m_drx, m_dtx, nrx, ntx, newr;
    int          vec;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_stat = '0; m_mask = '0; m_rx = 0; m_tx = 0;
            m_irq = 0; m_drx = 0; m_dtx = 0; m_rdata = '0;
        end else begin
            newr = (rev_strap >= 8'h34);
            pend = m_stat & {10'd0, m_mask};
            vec = 0;
            for (int b = 15; b >= 0; b--) if (pend[b]) vec = b + 1;
            ns = m_stat; nm = m_mask; nrx = m_rx; ntx = m_tx;
            if (reg_rd) begin
                m_tag = cur_tag;
                case (reg_sel)
                    3'd0: m_rdata = (m_stat & 16'hEFFF) | (bus_busy ? 16'h1000 : 16'h0);
                    3'd1: m_rdata = {10'd0, m_mask};
                    3'd2: m_rdata = {m_rx, 7'd0, m_tx, 7'd0};
                    3'd3: m_rdata = newr ? 16'd0 : 16'(vec);
                    default: m_rdata = 16'd0;
                endcase
                if (reg_sel == 3'd3 && !newr && vec != 0) ns[vec-1] = 1'b0;
            end
            if (reg_wr) begin
                case (reg_sel)
                    3'd0: if (newr) ns = ns & ~(reg_wdata & 16'h0027);
                    3'd1: nm = reg_wdata[5:0] & (newr ? 6'h3F : 6'h1F);
                    3'd2: begin
                        nrx = reg_wdata[15]; ntx = reg_wdata[7];
                        if (reg_wdata[15]) nm[3] = 1'b0;
                        if (reg_wdata[7])  nm[4] = 1'b0;
                    end
                    3'd4: if (newr && reg_wdata[11]) ns = ns | 16'h003F;
                    default: ;
                endcase
            end
            ns = ns | (evt_set & 16'hEFFF);
            if (soft_rst) begin ns = '0; nm = '0; nrx = 0; ntx = 0; end
            m_irq = (pend != 0);
            m_drx = m_rx & m_stat[3];
            m_dtx = m_tx & m_stat[4];
            m_stat = ns; m_mask = nm; m_rx = nrx; m_tx = ntx;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en && !done) begin
            check("R1", "irq", {15'd0, irq}, {15'd0, m_irq});
            check("R2", "dma_rx_req", {15'd0, dma_rx_req}, {15'd0, m_drx});
            check("R2", "dma_tx_req", {15'd0, dma_tx_req}, {15'd0, m_dtx});
            check(m_tag, "reg_rdata", reg_rdata, m_rdata);
        end
    end

    task automatic op(input logic [2:0] sel, input bit wr, input bit rd,
                      input logic [15:0] d, input logic [15:0] ev, input string t);
        @(negedge clk);
        reg_sel = sel; reg_wr = wr; reg_rd = rd; reg_wdata = d; evt_set = ev;
        soft_rst = 1'b0; cur_tag = t;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) op(3'd0, 0, 0, 16'h0, 16'h0, "R12");
    endtask

    task automatic sreset();
        @(negedge clk);
        reg_wr = 0; reg_rd = 0; evt_set = '0; soft_rst = 1'b1; cur_tag = "R11";
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #1000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state at the ports
        check("R11", "reset irq", {15'd0, irq}, 16'd0);
        check("R11", "reset dma", {14'd0, dma_rx_req, dma_tx_req}, 16'd0);
        check("R11", "reset rdata", reg_rdata, 16'd0);
        rst_n = 1'b1;
        chk_en = 1'b1;
        idle(2);

        // older revision
        op(3'd0, 0, 0, 0, 16'h000A, "R1");        // set bits 1 and 3
        op(3'd1, 1, 0, 16'h003F, 0, "R6");        // mask keeps 5 bits
        op(3'd1, 0, 1, 0, 0, "R6");
        op(3'd3, 0, 1, 0, 0, "R4");               // expect 2
        op(3'd0, 0, 1, 0, 0, "R4");               // bit1 cleared
        op(3'd3, 0, 1, 0, 0, "R4");               // expect 4
        op(3'd3, 0, 1, 0, 0, "R4");               // expect 0
        op(3'd0, 0, 0, 0, 16'h1023, "R8");        // bit 12 not stored
        op(3'd0, 1, 0, 16'hFFFF, 0, "R7");        // ignored in old rev
        op(3'd4, 1, 0, 16'h0800, 0, "R9");        // ignored in old rev
        bus_busy = 1'b1;
        op(3'd0, 0, 1, 0, 0, "R8");
        op(3'd4, 0, 1, 0, 0, "R9");
        bus_busy = 1'b0;
        op(3'd2, 1, 0, 16'hFFFF, 0, "R3");
        op(3'd2, 0, 1, 0, 0, "R3");
        op(3'd1, 0, 1, 0, 0, "R3");
        op(3'd0, 0, 0, 0, 16'h0018, "R2");
        idle(2);
        op(3'd2, 1, 0, 16'h0080, 0, "R2");        // receive DMA off
        idle(2);
        op(3'd3, 0, 1, 0, 16'h0001, "R10");       // vector ack vs set on bit 0
        op(3'd0, 0, 1, 0, 0, "R10");
        op(3'd7, 0, 1, 0, 0, "R12");
        idle(2);
        sreset();
        op(3'd0, 0, 1, 0, 0, "R11");
        op(3'd1, 0, 1, 0, 0, "R11");
        idle(1);

        // newer revision
        rev_strap = 8'h34;
        op(3'd1, 1, 0, 16'h00FF, 0, "R6");
        op(3'd1, 0, 1, 0, 0, "R6");
        op(3'd4, 1, 0, 16'h0800, 0, "R9");
        op(3'd0, 0, 1, 0, 0, "R9");
        op(3'd0, 1, 0, 16'hFFFF, 0, "R7");
        op(3'd0, 0, 1, 0, 0, "R7");
        op(3'd3, 0, 1, 0, 0, "R5");
        op(3'd0, 0, 1, 0, 0, "R5");
        op(3'd0, 1, 0, 16'h0001, 16'h0001, "R10");
        op(3'd0, 0, 1, 0, 0, "R10");
        idle(2);

        // mixed traffic against the model
        for (int k = 0; k < 600; k++) begin
            logic [2:0] s;
            string t;
            s = 3'($urandom_range(0, 5));
            case (s)
                3'd0: t = "R8";
                3'd1: t = "R6";
                3'd2: t = "R3";
                3'd3: t = "R4";
                default: t = "R12";
            endcase
            if (k == 300) rev_strap = 8'h12;
            bus_busy = 1'($urandom_range(0, 1));
            op(s, 1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 1)),
               16'($urandom), ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0, t);
            if ($urandom_range(0, 60) == 0) soft_rst = 1'b1;
        end
        idle(3);
        finish_run();
    end
endmodule